// File: doc/BRIEF.md
# TLB Entry Register-Access Unit

This block sits between a processor's banked support-register file and a small set-associative translation buffer. It holds four banks of sixteen 32-bit support registers and two TLB arrays, each of four ways by sixteen entries. The active bank comes from a 2-bit bank-select input. Banks 1 and 2 have MMU side effects. Bank 1 drives TLB array 0 and bank 2 drives TLB array 1. Banks 0 and 3 are plain storage.

In an MMU bank, four registers have fixed roles. Index 4 is the slot selector. Index 5 is the entry-low register and index 6 is the entry-high register. Index 7 is the fault-cause register. A write to entry-high also loads fault-cause. A write to entry-low commits a whole entry to the selected slot: the low word comes from the written data and the high word from fault-cause. If the entry being replaced was valid, the block issues a one-cycle page-invalidate request. The request carries the old entry's virtual page address, so a translation cache can drop that page.

A read in an MMU bank first reloads entry-high and entry-low from the selected slot, then returns the requested register. Lookups and page walks are handled elsewhere.

Top module: `tlb_regaccess`

## Requirements
- R1: After reset, every support register and every TLB entry is zero, `rd_data` is zero and `inv_valid` is low.
- R2: MMU side effects (the fault-cause copy, the entry commit, the mirror reload and the invalidate) happen only when `bank_sel` is 1 or 2. Bank 1 uses TLB array 0 and bank 2 uses TLB array 1. In banks 0 and 3, indices 5, 6 and 7 are ordinary registers.
- R3: A write to index 6 in an MMU bank stores the data in both index 6 and index 7 of that bank.
- R4: In the selector register (index 4 of the active bank), bits [3:0] pick the entry and bits [5:4] pick the way. All other bits of the selector are ignored.
- R5: A write to index 5 in an MMU bank stores the data in index 5. On the same clock edge it writes an entry to the selected slot, with the low word equal to the written data and the high word equal to the bank's index-7 value before that edge.
- R6: When a commit replaces an entry whose low-word bit 3 is set, `inv_valid` is high for the one cycle after the commit edge. In that cycle `inv_addr` equals the old high word with bits [12:0] cleared. Otherwise `inv_valid` stays low. `inv_addr` is zero whenever `inv_valid` is low.
- R7: A read returns its value on `rd_data` one cycle after `rd_en`. In an MMU bank, the read reloads indices 6 and 5 from the selected slot's high and low words. A read of index 5 or 6 returns the reloaded value.
- R8: When `wr_en` and `rd_en` are both high, the write is performed and the read is ignored: `rd_data` holds its value and no reload happens.
- R9: Each bank has its own sixteen registers. A write in one bank does not change another bank's registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 2 | Active support-register bank |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index to write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 4 | Register index to read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| inv_valid | output | 1 | One-cycle page-invalidate request |
| inv_addr | output | 32 | Page address of the invalidate request |

## Verification
The bench builds the block with its default parameters: four banks, two TLB arrays, four ways, sixteen entries and 8 KB pages. This configuration is small enough to sweep every slot of both arrays. The first pass fills each slot, with the valid bit set on alternate entries. The second pass reads each slot back through the mirror reload and then overwrites it. That checks, for every slot, whether an invalidate is raised and with which page address. A third readback confirms that each commit took its high word from fault-cause. Separate cases cover the plain banks 0 and 3, the ignored upper selector bits, and a read that collides with a write.

// File: rtl/tlbra_pkg.sv
package tlbra_pkg;

    localparam int DATA_W    = 32;
    localparam int IDX_SEL   = 4;
    localparam int IDX_LO    = 5;
    localparam int IDX_HI    = 6;
    localparam int IDX_CAUSE = 7;

    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } tlb_entry_t;

    function automatic logic bank_has_mmu(input logic [1:0] b);
        return (b == 2'd1) || (b == 2'd2);
    endfunction

endpackage

// File: rtl/tlbra_regbank.sv
module tlbra_regbank
    import tlbra_pkg::*;
#(
    parameter int NBANKS = 4,
    parameter int NREGS  = 16,
    localparam int BANK_W = $clog2(NBANKS),
    localparam int IDX_W  = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] bank,
    input  logic              mmu,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    input  tlb_entry_t        ent,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] sel_q,
    output logic [DATA_W-1:0] cause_q
);

    localparam logic [IDX_W-1:0] K_LO    = IDX_W'(IDX_LO);
    localparam logic [IDX_W-1:0] K_HI    = IDX_W'(IDX_HI);
    localparam logic [IDX_W-1:0] K_CAUSE = IDX_W'(IDX_CAUSE);
    localparam logic [IDX_W-1:0] K_SEL   = IDX_W'(IDX_SEL);

    logic [DATA_W-1:0] regs [NBANKS][NREGS];
    logic [DATA_W-1:0] rd_pick;

    always_comb begin
        if (mmu && rd_idx == K_HI)      rd_pick = ent.hi;
        else if (mmu && rd_idx == K_LO) rd_pick = ent.lo;
        else                            rd_pick = regs[bank][rd_idx];
    end

    assign sel_q   = regs[bank][K_SEL];
    assign cause_q = regs[bank][K_CAUSE];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANKS; b++) begin
                for (int r = 0; r < NREGS; r++) begin
                    regs[b][r] <= '0;
                end
            end
            rd_data <= '0;
        end else if (wr_en) begin
            regs[bank][wr_idx] <= wr_data;
            if (mmu && wr_idx == K_HI) begin
                regs[bank][K_CAUSE] <= wr_data;
            end
        end else if (rd_en) begin
            if (mmu) begin
                regs[bank][K_HI] <= ent.hi;
                regs[bank][K_LO] <= ent.lo;
            end
            rd_data <= rd_pick;
        end
    end

    AST_HI_COPIES_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && mmu && wr_idx == K_HI) |->
            regs[$past(bank)][K_CAUSE] == $past(wr_data)); // R3

    AST_COLLIDED_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en) |=> $stable(rd_data)); // R8

endmodule

// File: rtl/tlbra_store.sv
module tlbra_store
    import tlbra_pkg::*;
#(
    parameter int SETS    = 2,
    parameter int WAYS    = 4,
    parameter int ENTRIES = 16,
    localparam int SLOTS  = WAYS * ENTRIES,
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  set,
    input  logic [SLOT_W-1:0] slot,
    input  logic              we,
    input  tlb_entry_t        wdata,
    output tlb_entry_t        old
);

    tlb_entry_t mem [SETS][SLOTS];

    assign old = mem[set][slot];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int k = 0; k < SLOTS; k++) begin
                    mem[s][k] <= '0;
                end
            end
        end else if (we) begin
            mem[set][slot] <= wdata;
        end
    end

    AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (rst)
        $past(we) |-> mem[$past(set)][$past(slot)] == $past(wdata)); // R5

endmodule

// File: rtl/tlbra_inval.sv
module tlbra_inval
    import tlbra_pkg::*;
#(
    parameter int PAGE_BITS = 13,
    parameter int VALID_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  tlb_entry_t        old,
    output logic              inv_valid,
    output logic [DATA_W-1:0] inv_addr
);

    localparam logic [DATA_W-1:0] PAGE_MASK = DATA_W'((64'd1 << PAGE_BITS) - 1);

    logic fire;
    assign fire = commit && old.lo[VALID_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            inv_valid <= 1'b0;
            inv_addr  <= '0;
        end else begin
            inv_valid <= fire;
            inv_addr  <= fire ? (old.hi & ~PAGE_MASK) : '0;
        end
    end

endmodule

// File: rtl/tlb_regaccess.sv
module tlb_regaccess
    import tlbra_pkg::*;
#(
    parameter int NBANKS    = 4,
    parameter int NREGS     = 16,
    parameter int WAYS      = 4,
    parameter int ENTRIES   = 16,
    parameter int PAGE_BITS = 13,
    parameter int VALID_BIT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bank_sel,
    input  logic        wr_en,
    input  logic [3:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  logic [3:0]  rd_idx,
    output logic [31:0] rd_data,
    output logic        inv_valid,
    output logic [31:0] inv_addr
);

    localparam int SETS     = 2;
    localparam int SET_W    = $clog2(SETS);
    localparam int ENT_W    = $clog2(ENTRIES);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int WAY_LSB  = 4;
    localparam int SLOT_W   = ENT_W + WAY_W;

    logic              mmu;
    logic [SET_W-1:0]  tset;
    logic [SLOT_W-1:0] slot;
    logic [DATA_W-1:0] sel_q;
    logic [DATA_W-1:0] cause_q;
    logic              commit;
    tlb_entry_t        old_ent;
    tlb_entry_t        new_ent;

    assign mmu    = bank_has_mmu(bank_sel);
    assign tset   = SET_W'(bank_sel - 2'd1);
    assign slot   = {sel_q[WAY_LSB +: WAY_W], sel_q[0 +: ENT_W]};
    assign commit = wr_en && mmu && (wr_idx == 4'(IDX_LO));
    assign new_ent = '{hi: cause_q, lo: wr_data};

    tlbra_regbank #(.NBANKS(NBANKS), .NREGS(NREGS)) u_regs (
        .clk(clk), .rst(rst), .bank(bank_sel), .mmu(mmu),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .ent(old_ent),
        .rd_data(rd_data), .sel_q(sel_q), .cause_q(cause_q)
    );

    tlbra_store #(.SETS(SETS), .WAYS(WAYS), .ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst(rst), .set(tset), .slot(slot),
        .we(commit), .wdata(new_ent), .old(old_ent)
    );

    tlbra_inval #(.PAGE_BITS(PAGE_BITS), .VALID_BIT(VALID_BIT)) u_inval (
        .clk(clk), .rst(rst), .commit(commit), .old(old_ent),
        .inv_valid(inv_valid), .inv_addr(inv_addr)
    );

    AST_INV_ONLY_MMU_BANK: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> $past(mmu)); // R2

    AST_INV_NEEDS_OLD_VALID: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> $past(old_ent.lo[VALID_BIT])); // R6

    AST_INV_PAGE_MATCHES: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> inv_addr[31:PAGE_BITS] == $past(old_ent.hi[31:PAGE_BITS])); // R6

    AST_INV_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !inv_valid |-> inv_addr == '0); // R6

endmodule

// File: tb/tb_tlb_regaccess.sv
module tb_tlb_regaccess;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  bank_sel;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        inv_valid;
    logic [31:0] inv_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    tlb_regaccess dut (
        .clk(clk), .rst(rst), .bank_sel(bank_sel),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
        .inv_valid(inv_valid), .inv_addr(inv_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] b, input logic [3:0] i, input logic [31:0] d,
                         output logic iv, output logic [31:0] ia);
        @(negedge clk);
        bank_sel = b; wr_en = 1'b1; wr_idx = i; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        iv = inv_valid; ia = inv_addr;
    endtask

    task automatic do_rd(input logic [1:0] b, input logic [3:0] i, output logic [31:0] d);
        @(negedge clk);
        bank_sel = b; rd_en = 1'b1; rd_idx = i;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [31:0] hi1(input int b, input int w, input int e);
        return {4'(b), 4'(w), 8'(e), 16'h3C3C};
    endfunction

    function automatic logic [31:0] lo1(input int b, input int w, input int e);
        logic [7:0] ee = 8'(e);
        return {8'hA0, 4'(b), 4'(w), ee, 4'h6, ee[0], 3'b010};
    endfunction

    function automatic logic [31:0] sel_word(input int w, input int e);
        return 32'hFFFF_FFC0 | {26'd0, 2'(w), 4'(e)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic        iv;
        logic [31:0] ia, d, last;
        rst = 1'b1; bank_sel = '0; wr_en = 0; wr_idx = '0; wr_data = '0;
        rd_en = 0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 inv_valid", 32'(inv_valid), 32'h0);
        do_rd(2'd1, 4'd6, d); chk("R1 entry hi zero", d, 32'h0);
        do_rd(2'd0, 4'd9, d); chk("R1 reg zero", d, 32'h0);

        // R2: plain banks have no side effects
        for (int pb = 0; pb < 4; pb += 3) begin
            do_wr(2'(pb), 4'd6, 32'h1111_E000, iv, ia);
            do_wr(2'(pb), 4'd5, 32'h0000_0008, iv, ia);
            chk("R2 no invalidate in plain bank", 32'(iv), 32'h0);
            do_rd(2'(pb), 4'd7, d); chk("R2 no cause copy", d, 32'h0);
            do_rd(2'(pb), 4'd6, d); chk("R2 plain hi", d, 32'h1111_E000);
            do_rd(2'(pb), 4'd5, d); chk("R2 plain lo", d, 32'h0000_0008);
        end

        // R9: bank independence
        do_wr(2'd0, 4'd9, 32'hAAAA_0001, iv, ia);
        do_wr(2'd3, 4'd9, 32'hBBBB_0003, iv, ia);
        do_rd(2'd0, 4'd9, d); chk("R9 bank0 kept", d, 32'hAAAA_0001);
        do_rd(2'd3, 4'd9, d); chk("R9 bank3 kept", d, 32'hBBBB_0003);

        // Pass 1: fill every slot of both arrays (R3, R4, R5)
        for (int b = 1; b <= 2; b++) begin
            for (int w = 0; w < 4; w++) begin
                for (int e = 0; e < 16; e++) begin
                    do_wr(2'(b), 4'd4, sel_word(w, e), iv, ia);
                    do_wr(2'(b), 4'd6, hi1(b, w, e), iv, ia);
                    if (e == 0) begin
                        do_rd(2'(b), 4'd7, d); chk("R3 cause copy", d, hi1(b, w, e));
                    end
                    do_wr(2'(b), 4'd5, lo1(b, w, e), iv, ia);
                    chk("R6 no invalidate over empty slot", 32'(iv), 32'h0);
                    chk("R6 addr idle", ia, 32'h0);
                end
            end
        end

        // Pass 2: read back via reload, then overwrite (R2, R4, R6, R7)
        for (int b = 1; b <= 2; b++) begin
            for (int w = 0; w < 4; w++) begin
                for (int e = 0; e < 16; e++) begin
                    logic [31:0] oh, ol;
                    oh = hi1(b, w, e); ol = lo1(b, w, e);
                    do_wr(2'(b), 4'd4, sel_word(w, e), iv, ia);
                    do_rd(2'(b), 4'd6, d); chk("R7 reload hi", d, oh);
                    do_rd(2'(b), 4'd5, d); chk("R7 reload lo", d, ol);
                    do_wr(2'(b), 4'd6, ~oh, iv, ia);
                    do_wr(2'(b), 4'd5, ol ^ 32'hFF00_0008, iv, ia);
                    chk("R6 invalidate valid", 32'(iv), 32'(ol[3]));
                    chk("R6 invalidate addr", ia, ol[3] ? {oh[31:13], 13'd0} : 32'h0);
                end
            end
        end

        // Pass 3: commits took high word from fault-cause (R5)
        for (int b = 1; b <= 2; b++) begin
            for (int w = 0; w < 4; w++) begin
                for (int e = 0; e < 16; e += 5) begin
                    do_wr(2'(b), 4'd4, sel_word(w, e), iv, ia);
                    do_rd(2'(b), 4'd6, d); chk("R5 committed hi", d, ~hi1(b, w, e));
                    do_rd(2'(b), 4'd5, d); chk("R5 committed lo", d, lo1(b, w, e) ^ 32'hFF00_0008);
                end
            end
        end

        // R8: read colliding with write is ignored
        do_rd(2'd0, 4'd9, last);
        @(negedge clk);
        bank_sel = 2'd0; wr_en = 1; wr_idx = 4'd10; wr_data = 32'hC0DE_0010;
        rd_en = 1; rd_idx = 4'd3;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        chk("R8 rd_data held", rd_data, last);
        do_rd(2'd0, 4'd10, d); chk("R8 write performed", d, 32'hC0DE_0010);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule